// File: doc/BRIEF.md
# Event Timer Register Decoder

This block is the memory-mapped register file of a multi-timer event timer. A simple access port carries a valid strobe, a write flag, a 10-bit byte address, an access-size flag (32 or 64 bits) and 64-bit write data. Each access goes either to a small set of global registers or to one of several identical per-timer register slots. The slots are laid out at a fixed stride above the global area. All registers are 64 bits wide. Address bit 2 picks which 32-bit half a narrow access touches.

Writes are merged into the stored value through a fixed write mask for each register. Read-only and reserved bits therefore keep their values whatever the bus writes. A free-running main counter advances once per clock while the global enable bit is set. Read data is combinational: it follows the address in the same cycle as a read strobe and is zero when no read is presented. Comparator matching and interrupt generation are not part of this block.

Top module: `evt_timer_regs`

## Requirements
- R1: A read at 0x000 returns the capability word: revision 1 in bits 7:0 and the tick period 10,000,000 fs in bits 63:32, with all other bits 0 (64'h0098_9680_0000_0001). Writes to it have no effect.
- R2: The general configuration register at 0x010 resets to 0. Only bit 0 (run enable) and bit 1 (alternate routing) are writable. Bits 63:2 always read 0.
- R3: The interrupt status register at 0x020 resets to 0. Only its low NUM_TIMERS bits are writable, and the rest read 0.
- R4: The main counter at 0x0F0 resets to 0. While configuration bit 0 is set it increases by exactly 1 each clock and ignores writes. While bit 0 is clear it holds its value and accepts writes. A read returns its current value.
- R5: Timer n (n < NUM_TIMERS) occupies 0x100 + 0x20*n. Its offset 0x00 is configuration, 0x08 is the comparator and 0x10 is the route register. An access to one slot or register leaves every other register unchanged.
- R6: A write to a timer configuration register changes only the bits set in mask 0x7F4E. Bits 4 and 5 always read 1, bit 15 reads 0, bits 63:32 read the ROUTE_CAP parameter, and the other bits outside the mask read 0.
- R7: The timer comparator and route registers are fully writable 64-bit registers.
- R8: Address bit 2 set selects the upper half: a read returns the register shifted right by 32. A write replaces bits 63:32 with wdata[31:0], whatever the size. With bit 2 clear, a 32-bit write replaces bits 31:0 and a 64-bit write replaces all 64 bits.
- R9: Reserved addresses read 0, and writes to them change nothing. These are the global offsets other than the four above, timer offsets 0x18 and 0x1C, and any timer index at or above NUM_TIMERS.
- R10: After reset the timer comparator and route registers read 0, and each timer configuration register reads only its fixed read-only bits (64'h0000_0C00_0000_0030 with the default ROUTE_CAP).
- R11: When acc_valid is low, no register changes except the running counter, and acc_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the counter tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_size64 | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| acc_addr | input | 10 | Byte address |
| acc_wdata | input | 64 | Write data |
| acc_rdata | output | 64 | Read data, combinational, 0 when no read |

## Verification
The assertions watch, on every cycle, the invariants held in state and decode. These are the fixed bits of the configuration and status registers, the read-only bits of each timer configuration, counter stepping and holding, the at-most-one slot hit, zero data on reserved reads, and stillness while no access is presented. Only the bench scenarios can show the address map itself. That covers the half-word merging at each offset and size, and the absence of aliasing between slots. It also covers the fact that out-of-range timer indices and reserved offsets leave real registers untouched, and the exact counter values across enable and disable.

// File: rtl/evt_regs_pkg.sv
package evt_regs_pkg;

  localparam int DATA_W = 64;
  localparam int ADDR_W = 10;

  localparam logic [DATA_W-1:0] GLB_CFG_WMASK = 64'h0000_0000_0000_0003;
  localparam logic [DATA_W-1:0] TMR_CFG_WMASK = 64'h0000_0000_0000_7F4E;

  typedef enum logic [2:0] {
    GR_NONE,
    GR_CAP,
    GR_CFG,
    GR_STS,
    GR_CNT
  } glb_sel_e;

  typedef enum logic [1:0] {
    TR_CFG,
    TR_CMP,
    TR_ROUTE,
    TR_NONE
  } tmr_reg_e;

  // Merge bus data into a stored value: the half select and the size give
  // the written lane, and the register's mask limits it further.
  function automatic logic [DATA_W-1:0] merge_lane(
    input logic [DATA_W-1:0] old_val,
    input logic [DATA_W-1:0] wdata,
    input logic              hi_half,
    input logic              size64,
    input logic [DATA_W-1:0] wmask
  );
    logic [DATA_W-1:0] lane;
    logic [DATA_W-1:0] aligned;
    logic [DATA_W-1:0] en;
    if (hi_half) begin
      lane    = {32'hFFFF_FFFF, 32'h0};
      aligned = {wdata[31:0], 32'h0};
    end else begin
      lane    = size64 ? '1 : {32'h0, 32'hFFFF_FFFF};
      aligned = wdata;
    end
    en = lane & wmask;
    return (old_val & ~en) | (aligned & en);
  endfunction

endpackage

// File: rtl/evt_addr_decode.sv
module evt_addr_decode
  import evt_regs_pkg::*;
#(
  parameter int NUM_TIMERS = 3
) (
  input  logic [ADDR_W-1:0]     addr,
  output glb_sel_e              glb_sel,
  output tmr_reg_e              tmr_reg,
  output logic [NUM_TIMERS-1:0] tmr_hit,
  output logic                  hi_half
);

  logic [ADDR_W-1:0] a;
  logic [4:0]        slot;
  logic              in_tmr;

  assign hi_half = addr[2];
  assign a       = {addr[9:3], 1'b0, addr[1:0]};

  always_comb begin
    glb_sel = GR_NONE;
    tmr_reg = TR_NONE;
    slot    = '0;
    in_tmr  = 1'b0;
    if (a[9:8] == 2'b00) begin
      case (a[7:0])
        8'h00:   glb_sel = GR_CAP;
        8'h10:   glb_sel = GR_CFG;
        8'h20:   glb_sel = GR_STS;
        8'hF0:   glb_sel = GR_CNT;
        default: glb_sel = GR_NONE;
      endcase
    end else begin
      slot = a[9:5] - 5'd8;
      case (a[4:0])
        5'h00:   tmr_reg = TR_CFG;
        5'h08:   tmr_reg = TR_CMP;
        5'h10:   tmr_reg = TR_ROUTE;
        default: tmr_reg = TR_NONE;
      endcase
      in_tmr = (tmr_reg != TR_NONE);
    end
  end

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_hit
    assign tmr_hit[i] = in_tmr && (slot == 5'(i));
  end

endmodule

// File: rtl/evt_timer_slot.sv
module evt_timer_slot
  import evt_regs_pkg::*;
#(
  parameter logic [31:0] ROUTE_CAP = 32'h0000_0C00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  tmr_reg_e          reg_sel,
  input  logic              hi_half,
  input  logic              size64,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cfg_q,
  output logic [DATA_W-1:0] cmp_q,
  output logic [DATA_W-1:0] route_q
);

  localparam logic [DATA_W-1:0] CFG_RO = {ROUTE_CAP, 32'h0000_0030};

  logic [DATA_W-1:0] cfg_d, cmp_d, route_d;
  logic              cfg_ce, cmp_ce, route_ce;

  assign cfg_ce   = wr_en && (reg_sel == TR_CFG);
  assign cmp_ce   = wr_en && (reg_sel == TR_CMP);
  assign route_ce = wr_en && (reg_sel == TR_ROUTE);

  always_comb begin
    cfg_d   = merge_lane(cfg_q, wdata, hi_half, size64, TMR_CFG_WMASK);
    cmp_d   = merge_lane(cmp_q, wdata, hi_half, size64, '1);
    route_d = merge_lane(route_q, wdata, hi_half, size64, '1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= CFG_RO;
      cmp_q   <= '0;
      route_q <= '0;
    end else begin
      if (cfg_ce)   cfg_q   <= cfg_d;
      if (cmp_ce)   cmp_q   <= cmp_d;
      if (route_ce) route_q <= route_d;
    end
  end

  AST_TCFG_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q & ~TMR_CFG_WMASK) == CFG_RO); // R6

  AST_SLOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(cfg_q) && $stable(cmp_q) && $stable(route_q))); // R11

endmodule

// File: rtl/evt_main_counter.sv
module evt_main_counter
  import evt_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              wr_en,
  input  logic              hi_half,
  input  logic              size64,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cnt_q
);

  logic [DATA_W-1:0] cnt_d;
  logic              cnt_ce;

  assign cnt_ce = run || wr_en;

  always_comb begin
    if (run) cnt_d = cnt_q + 64'd1;
    else     cnt_d = merge_lane(cnt_q, wdata, hi_half, size64, '1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (cnt_q == $past(cnt_q) + 64'd1)); // R4

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_en) |=> $stable(cnt_q)); // R4

endmodule

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
  import evt_regs_pkg::*;
#(
  parameter int          NUM_TIMERS = 3,
  parameter int unsigned TICK_FS    = 10_000_000,
  parameter int unsigned REV_ID     = 1,
  parameter logic [31:0] ROUTE_CAP  = 32'h0000_0C00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic              acc_size64,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] acc_rdata
);

  localparam logic [DATA_W-1:0] CAP_VAL   = {32'(TICK_FS), 24'h0, 8'(REV_ID)};
  localparam logic [DATA_W-1:0] STS_WMASK = (64'd1 << NUM_TIMERS) - 64'd1;

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sn   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sn   <= rst_meta;
    end
  end

  glb_sel_e              glb_sel;
  tmr_reg_e              tmr_reg;
  logic [NUM_TIMERS-1:0] tmr_hit;
  logic                  hi_half;

  evt_addr_decode #(.NUM_TIMERS(NUM_TIMERS)) u_dec (
    .addr    (acc_addr),
    .glb_sel (glb_sel),
    .tmr_reg (tmr_reg),
    .tmr_hit (tmr_hit),
    .hi_half (hi_half)
  );

  logic bus_wr, bus_rd;
  assign bus_wr = acc_valid && acc_write;
  assign bus_rd = acc_valid && !acc_write;

  // Global configuration and interrupt status
  logic [DATA_W-1:0] gcfg_q, gcfg_d, sts_q, sts_d;
  logic              gcfg_ce, sts_ce;

  assign gcfg_ce = bus_wr && (glb_sel == GR_CFG);
  assign sts_ce  = bus_wr && (glb_sel == GR_STS);

  always_comb begin
    gcfg_d = merge_lane(gcfg_q, acc_wdata, hi_half, acc_size64, GLB_CFG_WMASK);
    sts_d  = merge_lane(sts_q, acc_wdata, hi_half, acc_size64, STS_WMASK);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      gcfg_q <= '0;
      sts_q  <= '0;
    end else begin
      if (gcfg_ce) gcfg_q <= gcfg_d;
      if (sts_ce)  sts_q  <= sts_d;
    end
  end

  // Main counter
  logic [DATA_W-1:0] cnt_q;

  evt_main_counter u_cnt (
    .clk     (clk),
    .rst_n   (rst_sn),
    .run     (gcfg_q[0]),
    .wr_en   (bus_wr && (glb_sel == GR_CNT)),
    .hi_half (hi_half),
    .size64  (acc_size64),
    .wdata   (acc_wdata),
    .cnt_q   (cnt_q)
  );

  // Per-timer slots
  logic [DATA_W-1:0] t_cfg   [NUM_TIMERS];
  logic [DATA_W-1:0] t_cmp   [NUM_TIMERS];
  logic [DATA_W-1:0] t_route [NUM_TIMERS];

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_slot
    evt_timer_slot #(.ROUTE_CAP(ROUTE_CAP)) u_slot (
      .clk     (clk),
      .rst_n   (rst_sn),
      .wr_en   (bus_wr && tmr_hit[i]),
      .reg_sel (tmr_reg),
      .hi_half (hi_half),
      .size64  (acc_size64),
      .wdata   (acc_wdata),
      .cfg_q   (t_cfg[i]),
      .cmp_q   (t_cmp[i]),
      .route_q (t_route[i])
    );
  end

  // Read path
  logic [DATA_W-1:0] tmr_rd, rd_full;

  always_comb begin
    tmr_rd = '0;
    for (int i = 0; i < NUM_TIMERS; i++) begin
      if (tmr_hit[i]) begin
        case (tmr_reg)
          TR_CFG:   tmr_rd = tmr_rd | t_cfg[i];
          TR_CMP:   tmr_rd = tmr_rd | t_cmp[i];
          TR_ROUTE: tmr_rd = tmr_rd | t_route[i];
          default:  tmr_rd = tmr_rd;
        endcase
      end
    end
  end

  always_comb begin
    case (glb_sel)
      GR_CAP:  rd_full = CAP_VAL;
      GR_CFG:  rd_full = gcfg_q;
      GR_STS:  rd_full = sts_q;
      GR_CNT:  rd_full = cnt_q;
      default: rd_full = tmr_rd;
    endcase
  end

  assign acc_rdata = bus_rd ? (hi_half ? (rd_full >> 32) : rd_full) : '0;

  // Checks
  AST_DEC_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_sn)
    $onehot0(tmr_hit) && !((glb_sel != GR_NONE) && (|tmr_hit))); // R5

  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_sn)
    (bus_rd && (glb_sel == GR_NONE) && (tmr_hit == '0)) |-> (acc_rdata == '0)); // R9

  AST_CAP_WORD: assert property (@(posedge clk) disable iff (!rst_sn)
    (bus_rd && (glb_sel == GR_CAP) && !hi_half) |-> (acc_rdata == CAP_VAL)); // R1

  AST_GCFG_FIXED: assert property (@(posedge clk) disable iff (!rst_sn)
    gcfg_q[63:2] == '0); // R2

  AST_STS_FIXED: assert property (@(posedge clk) disable iff (!rst_sn)
    (sts_q & ~STS_WMASK) == '0); // R3

  AST_IDLE_STILL: assert property (@(posedge clk) disable iff (!rst_sn)
    !acc_valid |=> ($stable(gcfg_q) && $stable(sts_q))); // R11

  AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_sn)
    !acc_valid |-> (acc_rdata == '0)); // R11

endmodule

// File: tb/evt_timer_regs_bench.sv
module evt_timer_regs_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid, acc_write, acc_size64;
  logic [9:0]  acc_addr;
  logic [63:0] acc_wdata;
  logic [63:0] acc_rdata;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_timer_regs u_evt_timer_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .acc_size64 (acc_size64),
    .acc_addr   (acc_addr),
    .acc_wdata  (acc_wdata),
    .acc_rdata  (acc_rdata)
  );

  // For reads, data holds the expected result.
  typedef struct packed {
    logic        wr;
    logic        sz64;
    logic [9:0]  addr;
    logic [63:0] data;
    logic [15:0] rq;
  } vec_t;

  localparam int NV = 42;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 10'h000, 64'h0098_9680_0000_0001, "R1"},
    '{1'b0, 1'b0, 10'h004, 64'h0000_0000_0098_9680, "R8"},
    '{1'b1, 1'b1, 10'h000, ONES,                    "R1"},
    '{1'b0, 1'b1, 10'h000, 64'h0098_9680_0000_0001, "R1"},
    '{1'b1, 1'b1, 10'h010, 64'hFFFF_FFFF_FFFF_FFFE, "R2"},
    '{1'b0, 1'b1, 10'h010, 64'h0000_0000_0000_0002, "R2"},
    '{1'b1, 1'b0, 10'h020, ONES,                    "R3"},
    '{1'b0, 1'b1, 10'h020, 64'h0000_0000_0000_0007, "R3"},
    '{1'b1, 1'b1, 10'h0F0, 64'h1234_5678_9ABC_DEF0, "R4"},
    '{1'b0, 1'b1, 10'h0F0, 64'h1234_5678_9ABC_DEF0, "R4"},
    '{1'b1, 1'b0, 10'h0F4, 64'h0000_0000_AAAA_BBBB, "R8"},
    '{1'b0, 1'b1, 10'h0F0, 64'hAAAA_BBBB_9ABC_DEF0, "R8"},
    '{1'b0, 1'b0, 10'h0F4, 64'h0000_0000_AAAA_BBBB, "R8"},
    '{1'b0, 1'b1, 10'h100, 64'h0000_0C00_0000_0030, "R10"},
    '{1'b1, 1'b1, 10'h100, ONES,                    "R6"},
    '{1'b0, 1'b1, 10'h100, 64'h0000_0C00_0000_7F7E, "R6"},
    '{1'b1, 1'b0, 10'h104, ONES,                    "R6"},
    '{1'b0, 1'b1, 10'h100, 64'h0000_0C00_0000_7F7E, "R6"},
    '{1'b1, 1'b1, 10'h128, 64'h1111_2222_3333_4444, "R7"},
    '{1'b0, 1'b1, 10'h128, 64'h1111_2222_3333_4444, "R7"},
    '{1'b0, 1'b1, 10'h108, 64'h0,                   "R5"},
    '{1'b1, 1'b0, 10'h12C, 64'h0000_0000_5555_6666, "R8"},
    '{1'b0, 1'b1, 10'h128, 64'h5555_6666_3333_4444, "R8"},
    '{1'b1, 1'b1, 10'h12C, 64'hDEAD_BEEF_7777_8888, "R8"},
    '{1'b0, 1'b1, 10'h128, 64'h7777_8888_3333_4444, "R8"},
    '{1'b1, 1'b1, 10'h150, 64'h0000_0000_0000_CAFE, "R7"},
    '{1'b0, 1'b1, 10'h150, 64'h0000_0000_0000_CAFE, "R7"},
    '{1'b1, 1'b0, 10'h150, 64'hFFFF_FFFF_0000_1234, "R8"},
    '{1'b0, 1'b1, 10'h150, 64'h0000_0000_0000_1234, "R8"},
    '{1'b1, 1'b1, 10'h118, ONES,                    "R9"},
    '{1'b0, 1'b1, 10'h118, 64'h0,                   "R9"},
    '{1'b0, 1'b0, 10'h11C, 64'h0,                   "R9"},
    '{1'b1, 1'b1, 10'h168, ONES,                    "R9"},
    '{1'b0, 1'b1, 10'h168, 64'h0,                   "R9"},
    '{1'b0, 1'b1, 10'h128, 64'h7777_8888_3333_4444, "R9"},
    '{1'b1, 1'b1, 10'h030, ONES,                    "R9"},
    '{1'b0, 1'b1, 10'h030, 64'h0,                   "R9"},
    '{1'b0, 1'b1, 10'h3E8, 64'h0,                   "R9"},
    '{1'b0, 1'b1, 10'h110, 64'h0,                   "R5"},
    '{1'b0, 1'b1, 10'h148, 64'h0,                   "R5"},
    '{1'b1, 1'b1, 10'h010, 64'h0,                   "R2"},
    '{1'b0, 1'b1, 10'h010, 64'h0,                   "R2"}
  };

  task automatic do_wr(input logic [9:0] a, input logic sz, input logic [63:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_size64 = sz; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic do_rd(input logic [9:0] a, input logic sz, input logic [63:0] exp,
                       input string rq);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0; acc_size64 = sz; acc_addr = a; acc_wdata = '0;
    #1;
    checks++;
    if (acc_rdata !== exp) begin
      errors++;
      $display("FAIL %s addr %h: got %h expected %h", rq, a, acc_rdata, exp);
    end
  endtask

  task automatic chk_idle(input logic [63:0] exp, input string rq);
    #1;
    checks++;
    if (acc_rdata !== exp) begin
      errors++;
      $display("FAIL %s idle rdata: got %h expected %h", rq, acc_rdata, exp);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; acc_valid = 1'b0; acc_write = 1'b0; acc_size64 = 1'b1;
    acc_addr = '0; acc_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R10 / R2 / R3 / R4: reset values
    do_rd(10'h010, 1'b1, 64'h0, "R2");
    do_rd(10'h020, 1'b1, 64'h0, "R3");
    do_rd(10'h0F0, 1'b1, 64'h0, "R4");
    do_rd(10'h150, 1'b1, 64'h0, "R10");

    for (int k = 0; k < NV; k++) begin
      if (VECS[k].wr) do_wr(VECS[k].addr, VECS[k].sz64, VECS[k].data);
      else            do_rd(VECS[k].addr, VECS[k].sz64, VECS[k].data,
                            $sformatf("%s", VECS[k].rq));
    end

    // R4: counter runs, ignores writes while running, freezes when stopped
    do_wr(10'h0F0, 1'b1, 64'd100);
    do_wr(10'h010, 1'b1, 64'd1);
    do_rd(10'h0F0, 1'b1, 64'd101, "R4");
    repeat (4) @(negedge clk);
    do_rd(10'h0F0, 1'b1, 64'd106, "R4");
    do_wr(10'h0F0, 1'b1, 64'd0);
    do_rd(10'h0F0, 1'b1, 64'd109, "R4");
    do_wr(10'h010, 1'b1, 64'd0);
    do_rd(10'h0F0, 1'b1, 64'd111, "R4");
    repeat (3) @(negedge clk);
    do_rd(10'h0F0, 1'b1, 64'd111, "R4");

    // R11: a write strobe without valid changes nothing; idle rdata is 0
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b1; acc_size64 = 1'b1;
    acc_addr = 10'h128; acc_wdata = ONES;
    chk_idle(64'h0, "R11");
    @(negedge clk);
    acc_write = 1'b0;
    do_rd(10'h128, 1'b1, 64'h7777_8888_3333_4444, "R11");
    do_rd(10'h0F0, 1'b1, 64'd111, "R11");

    // R10: reset again mid-run
    do_wr(10'h128, 1'b1, ONES);
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    do_rd(10'h128, 1'b1, 64'h0, "R10");
    do_rd(10'h100, 1'b1, 64'h0000_0C00_0000_0030, "R10");
    do_rd(10'h0F0, 1'b1, 64'h0, "R10");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule